// File: doc/BRIEF.md
# Compressed Immediate Expander

This block turns the 12-bit packed immediate held in an instruction word into a full 32-bit constant. It also produces the shifter carry that goes with that constant. It is purely combinational. A decode stage drives it with the raw instruction word, the current carry flag and a 3-bit mode, and takes back the constant, the carry and a flag for encodings whose result is not defined.

There are two rotation encodings:
- The wide encoding rotates an 8-bit value right by an even amount.
- The compact encoding gathers its 12-bit field from bits spread across the word. The field then either replicates a byte in one of four layouts, or rotates a byte whose top bit is implicitly one.

Three helper modes return the gathered 12-bit field zero-extended, or a 7-bit or 8-bit offset scaled to words.

Top module: `imm_expander`

## Requirements
- R1: Mode 0 (wide): the result is insn_i[7:0] zero-extended to 32 bits and rotated right by 2*insn_i[11:8].
- R2: Mode 0: when insn_i[11:8] is zero, carry_o equals carry_i. Otherwise carry_o equals bit 31 of the result.
- R3: Modes 1 and 2 assemble a 12-bit field, most to least significant, from insn_i[26], insn_i[14:12] and insn_i[7:0]. No other instruction bit affects the outputs in these modes.
- R4: Mode 1 with field[11:10]=00 replicates the byte B=field[7:0] according to field[9:8]:
  - 00 gives B zero-extended.
  - 01 gives 0x00B00B.
  - 10 gives 0xB00B00.
  - 11 gives 0xBBBBBBBB.
  In all four cases carry_o equals carry_i.
- R5: Mode 1 with field[11:10]!=00: the value {1'b1, field[6:0]}, zero-extended, is rotated right by field[11:7]. carry_o is bit 31 of that result.
- R6: unpred_o is 1 only in mode 1 when field[11:10]=00, field[9:8]!=00 and field[7:0]=0. In every other case it is 0.
- R7: Mode 2 returns the 12-bit field zero-extended to 32 bits.
- R8: Mode 3 returns insn_i[6:0]*4. Mode 4 returns insn_i[7:0]*4.
- R9: In modes 2, 3 and 4, carry_o equals carry_i. Modes 5, 6 and 7 are reserved: they return zero, with carry_o equal to carry_i and unpred_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 3 | Expansion mode: 0 wide, 1 compact, 2 plain field, 3 scaled 7-bit, 4 scaled 8-bit |
| insn_i | input | 32 | Raw instruction word |
| carry_i | input | 1 | Incoming carry flag |
| imm_o | output | 32 | Expanded constant |
| carry_o | output | 1 | Shifter carry that goes with the constant |
| unpred_o | output | 1 | Result of this encoding is not defined |

## Verification
There is no state, so a fault shows in the same cycle as the input that exposes it. A wrong rotate amount or direction changes the popcount-preserving position of the byte. A mis-gathered field bit shows up only when insn_i[26] or insn_i[14:12] is set, so the vectors set those bits alone and also set all the unused bits. Carry errors hide whenever the result's bit 31 happens to match carry_i, so the vectors pair each carry case with the opposite carry_i.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 12;
  localparam int ROT_W   = $clog2(WORD_W);
  localparam int LANES   = WORD_W / BYTE_W;

  typedef enum logic [2:0] {
    MODE_WIDE    = 3'd0,
    MODE_COMPACT = 3'd1,
    MODE_PLAIN   = 3'd2,
    MODE_SCALE7  = 3'd3,
    MODE_SCALE8  = 3'd4
  } mode_e;

  function automatic logic [WORD_W-1:0] ror_word(logic [WORD_W-1:0] v, logic [ROT_W-1:0] n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} >> n;
    return dbl[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/imm_wide_rot.sv
module imm_wide_rot
  import imm_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               carry_i,
  output logic [WORD_W-1:0]  imm_o,
  output logic               carry_o
);
  logic [ROT_W-1:0] amt;
  logic [BYTE_W-1:0] val;

  assign val   = field_i[BYTE_W-1:0];
  assign amt   = ROT_W'({field_i[FIELD_W-1:BYTE_W], 1'b0});
  assign imm_o = ror_word(WORD_W'(val), amt);
  assign carry_o = (amt == '0) ? carry_i : imm_o[WORD_W-1];

  always_comb begin
    assert_rot_keeps_bits_R1: assert ($countones(imm_o) == $countones(val));
    if (field_i[FIELD_W-1:BYTE_W] == '0)
      assert_zero_rot_carry_R2: assert (carry_o == carry_i && imm_o == WORD_W'(val));
  end
endmodule

// File: rtl/imm_compact.sv
module imm_compact
  import imm_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               carry_i,
  output logic [WORD_W-1:0]  imm_o,
  output logic               carry_o,
  output logic               unpred_o
);
  logic [BYTE_W-1:0] b;
  logic              rep_sel;
  logic [WORD_W-1:0] rep_val;
  logic [WORD_W-1:0] rot_val;

  assign b       = field_i[BYTE_W-1:0];
  assign rep_sel = (field_i[FIELD_W-1:FIELD_W-2] == 2'b00);

  // byte lanes: even lanes for pattern 01, odd lanes for 10, all for 11
  always_comb begin
    rep_val = '0;
    for (int l = 0; l < LANES; l++) begin
      case (field_i[9:8])
        2'b00:   if (l == 0)     rep_val[l*BYTE_W +: BYTE_W] = b;
        2'b01:   if (l % 2 == 0) rep_val[l*BYTE_W +: BYTE_W] = b;
        2'b10:   if (l % 2 == 1) rep_val[l*BYTE_W +: BYTE_W] = b;
        default:                 rep_val[l*BYTE_W +: BYTE_W] = b;
      endcase
    end
  end

  assign rot_val  = ror_word(WORD_W'({1'b1, field_i[6:0]}), ROT_W'(field_i[11:7]));
  assign imm_o    = rep_sel ? rep_val : rot_val;
  assign carry_o  = rep_sel ? carry_i : rot_val[WORD_W-1];
  assign unpred_o = rep_sel && (field_i[9:8] != 2'b00) && (b == '0);

  always_comb begin
    if (rep_sel && field_i[9:8] == 2'b11)
      assert_full_rep_R4: assert ($countones(imm_o) == LANES * $countones(b));
    if (rep_sel)
      assert_rep_carry_R4: assert (carry_o == carry_i);
    if (!rep_sel)
      assert_rot_nonzero_R5: assert (imm_o != '0 &&
        $countones(imm_o) == 1 + $countones(field_i[6:0]));
    if (unpred_o)
      assert_unpred_zero_byte_R6: assert (imm_o == '0);
  end
endmodule

// File: rtl/imm_offsets.sv
module imm_offsets
  import imm_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic [BYTE_W-1:0]  low_i,
  output logic [WORD_W-1:0]  plain_o,
  output logic [WORD_W-1:0]  s7_o,
  output logic [WORD_W-1:0]  s8_o
);
  assign plain_o = WORD_W'(field_i);
  assign s7_o    = WORD_W'({low_i[6:0], 2'b00});
  assign s8_o    = WORD_W'({low_i, 2'b00});

  always_comb begin
    assert_word_aligned_R8: assert (s7_o[1:0] == 2'b00 && s8_o[1:0] == 2'b00
                                    && s7_o <= s8_o);
  end
endmodule

// File: rtl/imm_expander.sv
module imm_expander
  import imm_pkg::*;
(
  input  logic [2:0]  mode_i,
  input  logic [31:0] insn_i,
  input  logic        carry_i,
  output logic [31:0] imm_o,
  output logic        carry_o,
  output logic        unpred_o
);
  logic [FIELD_W-1:0] wide_field, cmp_field;
  logic [WORD_W-1:0]  wide_imm, cmp_imm, plain_imm, s7_imm, s8_imm;
  logic               wide_c, cmp_c, cmp_u;
  logic               unused_bits;

  assign wide_field  = insn_i[11:0];
  assign cmp_field   = {insn_i[26], insn_i[14:12], insn_i[7:0]};
  assign unused_bits = ^{insn_i[31:27], insn_i[25:15]};

  imm_wide_rot u_wide (
    .field_i(wide_field), .carry_i(carry_i), .imm_o(wide_imm), .carry_o(wide_c)
  );

  imm_compact u_cmp (
    .field_i(cmp_field), .carry_i(carry_i), .imm_o(cmp_imm), .carry_o(cmp_c),
    .unpred_o(cmp_u)
  );

  imm_offsets u_off (
    .field_i(cmp_field), .low_i(insn_i[7:0]), .plain_o(plain_imm),
    .s7_o(s7_imm), .s8_o(s8_imm)
  );

  always_comb begin
    imm_o    = '0;
    carry_o  = carry_i;
    unpred_o = 1'b0;
    case (mode_i)
      MODE_WIDE:    begin imm_o = wide_imm; carry_o = wide_c; end
      MODE_COMPACT: begin imm_o = cmp_imm;  carry_o = cmp_c; unpred_o = cmp_u; end
      MODE_PLAIN:   imm_o = plain_imm;
      MODE_SCALE7:  imm_o = s7_imm;
      MODE_SCALE8:  imm_o = s8_imm;
      default:      ;
    endcase
  end

  always_comb begin
    if (mode_i > 3'd4)
      assert_reserved_zero_R9: assert (imm_o == '0 && carry_o == carry_i && !unpred_o);
    if (mode_i != 3'd1)
      assert_unpred_only_compact_R6: assert (!unpred_o);
    if (mode_i == 3'd2)
      assert_plain_width_R7: assert (imm_o[31:12] == '0);
  end
endmodule

// File: tb/tb_imm_expander.sv
`timescale 1ns/1ps
module tb_imm_expander;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  mode_i;
  logic [31:0] insn_i;
  logic        carry_i;
  logic [31:0] imm_o;
  logic        carry_o, unpred_o;

  int n_run = 0, n_fail = 0;

  imm_expander dut (.*);

  // {mode, insn, carry_in, exp_imm, exp_carry, exp_unpred}
  localparam int NV = 27;
  localparam logic [69:0] VEC [NV] = '{
    {3'd0, 32'h0000_00FF, 1'b1, 32'h0000_00FF, 1'b1, 1'b0}, // R2 rot 0 carry passes
    {3'd0, 32'h0000_00FF, 1'b0, 32'h0000_00FF, 1'b0, 1'b0}, // R2
    {3'd0, 32'h0000_0104, 1'b1, 32'h0000_0001, 1'b0, 1'b0}, // R1 ror 2
    {3'd0, 32'h0000_04FF, 1'b0, 32'hFF00_0000, 1'b1, 1'b0}, // R1 R2 ror 8
    {3'd0, 32'h0000_0F01, 1'b1, 32'h0000_0004, 1'b0, 1'b0}, // R1 ror 30
    {3'd0, 32'h0000_0102, 1'b0, 32'h8000_0000, 1'b1, 1'b0}, // R2 bit31 carry
    {3'd0, 32'h0000_0100, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R6 no flag in wide
    {3'd1, 32'h0000_00AB, 1'b1, 32'h0000_00AB, 1'b1, 1'b0}, // R4 pattern 00
    {3'd1, 32'h0000_10AB, 1'b0, 32'h00AB_00AB, 1'b0, 1'b0}, // R4 pattern 01
    {3'd1, 32'h0000_20AB, 1'b1, 32'hAB00_AB00, 1'b1, 1'b0}, // R4 pattern 10
    {3'd1, 32'h0000_30AB, 1'b0, 32'hABAB_ABAB, 1'b0, 1'b0}, // R4 pattern 11
    {3'd1, 32'h0000_3000, 1'b1, 32'h0000_0000, 1'b1, 1'b1}, // R6 zero byte 11
    {3'd1, 32'h0000_1000, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R6 zero byte 01
    {3'd1, 32'h0000_2000, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R6 zero byte 10
    {3'd1, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 1'b0}, // R6 pattern 00 no flag
    {3'd1, 32'h0000_4000, 1'b0, 32'h8000_0000, 1'b1, 1'b0}, // R5 ror 8
    {3'd1, 32'h0400_70FF, 1'b1, 32'h0000_01FE, 1'b0, 1'b0}, // R5 ror 31
    {3'd1, 32'h0400_0000, 1'b1, 32'h0080_0000, 1'b0, 1'b0}, // R3 bit26 alone
    {3'd1, 32'hFBFF_8F00, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R3 unused bits set
    {3'd2, 32'hFFFF_FFFF, 1'b0, 32'h0000_0FFF, 1'b0, 1'b0}, // R7
    {3'd2, 32'h0000_50C3, 1'b1, 32'h0000_05C3, 1'b1, 1'b0}, // R7 R3 R9
    {3'd3, 32'hFFFF_FFFF, 1'b1, 32'h0000_01FC, 1'b1, 1'b0}, // R8 scale7
    {3'd3, 32'h0000_0085, 1'b0, 32'h0000_0014, 1'b0, 1'b0}, // R8
    {3'd4, 32'hFFFF_FFFF, 1'b0, 32'h0000_03FC, 1'b0, 1'b0}, // R8 scale8
    {3'd4, 32'h0000_0085, 1'b1, 32'h0000_0214, 1'b1, 1'b0}, // R8
    {3'd5, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b1, 1'b0}, // R9 reserved
    {3'd7, 32'h0000_3000, 1'b0, 32'h0000_0000, 1'b0, 1'b0}  // R9 reserved
  };

  task automatic apply(input logic [2:0] m, input logic [31:0] w, input logic c);
    @(posedge clk);
    #1;
    mode_i = m; insn_i = w; carry_i = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] ei, input logic ec, input logic eu);
    n_run++;
    if (imm_o !== ei || carry_o !== ec || unpred_o !== eu) begin
      n_fail++;
      $display("FAIL %s: mode=%0d insn=%h cin=%b got imm=%h c=%b u=%b exp imm=%h c=%b u=%b",
               req, mode_i, insn_i, carry_i, imm_o, carry_o, unpred_o, ei, ec, eu);
    end
  endtask

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    mode_i = '0; insn_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][69:67], VEC[i][66:35], VEC[i][34]);
      check($sformatf("vec%0d", i), VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R3: bits [14:12] land at field[10:8]
    apply(3'd2, 32'h0000_7000, 1'b0);
    check("R3 mid bits", 32'h0000_0700, 1'b0, 1'b0);
    // R5: smallest rotate into compact rotated form, carry_in opposite
    apply(3'd1, 32'h0000_407F, 1'b0);
    check("R5 full low bits", 32'hFF00_0000, 1'b1, 1'b0);
    // R1: max wide rotate on full byte
    apply(3'd0, 32'h0000_0FFF, 1'b0);
    check("R1 ror 30 byte", 32'h0000_03FC, 1'b0, 1'b0);
    // R9: mode 6 with carry high
    apply(3'd6, 32'h0400_40FF, 1'b1);
    check("R9 mode6", 32'h0, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule